// File: doc/BRIEF.md
# Cascaded Converter Chain Readout Controller

This block sits on the host side of a string of serially cascaded sampling converters. All of them share one serial data line back to the host. Each converter passes on the output of the converter behind it, so the host sees one long bit stream. The stream holds a 16-bit result from every device. A single separator bit sits between consecutive results, and an optional one-bit synchronisation lead-in comes before the first result.

On a start pulse the controller emits a one-cycle read strobe. It then generates a gated data clock burst of exactly the length the chain needs, and holds that clock low at all other times. The data clock is derived from the system clock, and each of its phases lasts a programmable number of system cycles. The controller samples the serial line on every falling edge of the data clock. It drops the lead-in and the separators, and it delivers each 16-bit word in parallel with a valid flag and the word's position in the chain. A non-zero separator sets a sticky framing-error flag. After the last word a one-cycle done flag marks the end of the burst, and the controller returns to idle.

The host must issue the start early in the converters' sampling window, so that the burst finishes before the next conversion begins.

Top module: `chain_rd_ctrl`

## Requirements
- R1: During and after reset, sclk_o, rd_o, word_vld_o, done_o and frame_err_o are all 0.
- R2: A start_i pulse is accepted only while the controller is idle and only if 1 <= chain_len_i <= MAX_DEV. An accepted start gives rd_o high for exactly the one cycle after the start cycle. A start with any other length, or a start during a burst, produces no strobe and no clock.
- R3: One burst has exactly 17*N - 1 rising edges of sclk_o, plus one more when sync_en_i was 1 at start. N is the chain length. sclk_o is low whenever no burst is running.
- R4: Each high and each low phase of sclk_o lasts half_div_i system cycles, and a value of 0 is treated as 1.
- R5: sdata_i is sampled on each falling edge of sclk_o. Each word is 16 bits, MSB first. Words appear on word_o with word_vld_o high for one cycle. word_idx_o runs 0, 1, ..., N-1 in arrival order, where index 0 is the device nearest the host.
- R6: When sync_en_i is 1 at start, the bit sampled on the first falling edge is discarded, and the first data bit is taken on the second falling edge.
- R7: The bit after each of the first N-1 words is a separator and is never part of a word. A separator sampled as 1 sets frame_err_o. frame_err_o stays set until the next accepted start clears it.
- R8: done_o is high for exactly one cycle, namely the cycle right after the valid cycle of word N-1. From then on sclk_o stays low and a new start is accepted.
- R9: chain_len_i, sync_en_i and half_div_i are captured at the accepted start, and changes to them during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to read the chain |
| chain_len_i | input | $clog2(MAX_DEV+1) | Number of cascaded devices N |
| sync_en_i | input | 1 | 1: expect one synchronisation bit before the data |
| half_div_i | input | DIV_W | System cycles per data clock phase (0 acts as 1) |
| sdata_i | input | 1 | Serial data from the last device of the chain |
| sclk_o | output | 1 | Gated data clock to the chain |
| rd_o | output | 1 | One-cycle read command |
| word_o | output | WORD_W | Deserialized word |
| word_idx_o | output | $clog2(MAX_DEV) | Position of word_o in the chain |
| word_vld_o | output | 1 | word_o and word_idx_o valid |
| done_o | output | 1 | One-cycle end-of-burst flag |
| frame_err_o | output | 1 | Sticky flag: a separator read as 1 |

## Verification
Some properties are checked by assertions on every cycle. These cover the clock being held low outside a burst, and the strobe, valid and done flags being single-cycle pulses in the right order. They also cover word indices staying below the captured length and the error flag clearing only through a new start. Other behaviour can only be shown by the bench's sweep over chain length, lead-in setting and divider ratio, driven by a bit-level model of the chain. That includes the exact pulse count per burst and the phase width in system cycles. It also includes discarding the lead-in and the separators, the bit order and word content, the latching of configuration at start, and the rejection of illegal or overlapping starts.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_DONE  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/chain_sclk_gen.sv
module chain_sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             sclk_q;
  logic             wrap;

  assign lim  = (half_i == '0) ? '0 : half_i - DIV_W'(1);
  assign wrap = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end

  assign sclk_o = sclk_q;
  // high->low transition happens at this edge
  assign fall_o = run_i && wrap && sclk_q;
endmodule

// File: rtl/chain_frame_ctr.sv
module chain_frame_ctr #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned LEN_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             sync_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fall_i,
  output logic             take_o,
  output logic             sep_o,
  output logic             word_end_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] SEP_POS = BIT_W'(WORD_W);
  localparam logic [BIT_W-1:0] LSB_POS = BIT_W'(WORD_W - 1);

  logic             sync_pend_q;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] dev_q;

  assign sep_o      = fall_i && !sync_pend_q && (bit_q == SEP_POS);
  assign take_o     = fall_i && !sync_pend_q && (bit_q != SEP_POS);
  assign word_end_o = take_o && (bit_q == LSB_POS);
  assign last_o     = word_end_o && (LEN_W'(dev_q) == len_i - LEN_W'(1));
  assign idx_o      = dev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_pend_q <= 1'b0;
      bit_q       <= '0;
      dev_q       <= '0;
    end else if (load_i) begin
      sync_pend_q <= sync_i;
      bit_q       <= '0;
      dev_q       <= '0;
    end else if (fall_i) begin
      if (sync_pend_q) begin
        sync_pend_q <= 1'b0;
      end else if (bit_q == SEP_POS) begin
        bit_q <= '0;
      end else if (bit_q == LSB_POS) begin
        bit_q <= SEP_POS;
        dev_q <= dev_q + IDX_W'(1);
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/chain_deser.sv
module chain_deser #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              bit_i,
  input  logic              end_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              vld_o
);
  logic [WORD_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_o <= '0;
      idx_o  <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (take_i) begin
        if (end_i) begin
          word_o <= {sh_q, bit_i};
          idx_o  <= idx_i;
          vld_o  <= 1'b1;
        end else begin
          sh_q <= {sh_q[WORD_W-3:0], bit_i};
        end
      end
    end
  end
endmodule

// File: rtl/chain_rd_ctrl.sv
module chain_rd_ctrl
  import chain_rd_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned MAX_DEV = 4,
  parameter int unsigned DIV_W   = 8,
  localparam int unsigned LEN_W  = $clog2(MAX_DEV + 1),
  localparam int unsigned IDX_W  = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  chain_len_i,
  input  logic              sync_en_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              rd_o,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              word_vld_o,
  output logic              done_o,
  output logic              frame_err_o
);
  rd_state_e        state_q;
  logic [LEN_W-1:0] len_q;
  logic [DIV_W-1:0] half_q;
  logic             rd_q, done_q, err_q;
  logic             accept, run;
  logic             fall, take, sep, word_end, last;
  logic [IDX_W-1:0] idx;

  assign accept = (state_q == ST_IDLE) && start_i && (chain_len_i != '0)
                  && (chain_len_i <= LEN_W'(MAX_DEV));
  assign run    = (state_q == ST_BURST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      half_q  <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rd_q   <= accept;
      done_q <= (state_q == ST_DONE);
      if (sep && sdata_i) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          len_q   <= chain_len_i;
          half_q  <= half_div_i;
          err_q   <= 1'b0;
          state_q <= ST_BURST;
        end
        ST_BURST: if (last) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  chain_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (half_q),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  chain_frame_ctr #(.WORD_W(WORD_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_frm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .sync_i     (sync_en_i),
    .len_i      (len_q),
    .fall_i     (fall),
    .take_o     (take),
    .sep_o      (sep),
    .word_end_o (word_end),
    .last_o     (last),
    .idx_o      (idx)
  );

  chain_deser #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_des (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .bit_i  (sdata_i),
    .end_i  (word_end),
    .idx_i  (idx),
    .word_o (word_o),
    .idx_o  (word_idx_o),
    .vld_o  (word_vld_o)
  );

  assign rd_o        = rd_q;
  assign done_o      = done_q;
  assign frame_err_o = err_q;
endmodule

// File: rtl/chain_rd_ctrl_chk.sv
module chain_rd_ctrl_chk #(
  parameter int unsigned LEN_W = 3,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [LEN_W-1:0] len_i,
  input logic             sclk_o,
  input logic             rd_o,
  input logic [IDX_W-1:0] word_idx_o,
  input logic             word_vld_o,
  input logic             done_o,
  input logic             frame_err_o
);
  a_r3_clk_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !sclk_o);

  a_r2_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o);

  a_r2_rd_opens_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> run_i && !sclk_o);

  a_r5_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (LEN_W'(word_idx_o) < len_i));

  a_r5_vld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_after_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(word_vld_o) && !run_i && !sclk_o);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> (frame_err_o || rd_o));
endmodule

bind chain_rd_ctrl chain_rd_ctrl_chk #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run),
  .len_i       (len_q),
  .sclk_o      (sclk_o),
  .rd_o        (rd_o),
  .word_idx_o  (word_idx_o),
  .word_vld_o  (word_vld_o),
  .done_o      (done_o),
  .frame_err_o (frame_err_o)
);

// File: tb/chain_rd_ctrl_tb.sv
module chain_rd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W  = 16;
  localparam int MAX_DEV = 4;
  localparam int DIV_W   = 8;
  localparam int LEN_W   = 3;
  localparam int IDX_W   = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sync_en = 1'b0, sdata = 1'b0;
  logic [LEN_W-1:0]  len  = '0;
  logic [DIV_W-1:0]  half = '0;
  logic              sclk, rd, vld, done, ferr;
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  widx;

  int vectors = 0, miscompares = 0;

  bit          sb [0:127];
  int          sb_len = 0, sb_ptr = 0;
  logic [15:0] exp_word [0:MAX_DEV-1];
  int          exp_n = 1;
  int          pulse_cnt = 0, hi_cnt = 0, got_words = 0, next_idx = 0;
  int          done_cnt = 0, rd_cnt = 0;
  bit          vld_last_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_rd_ctrl #(.WORD_W(WORD_W), .MAX_DEV(MAX_DEV), .DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chain_len_i(len),
    .sync_en_i(sync_en), .half_div_i(half), .sdata_i(sdata),
    .sclk_o(sclk), .rd_o(rd), .word_o(word), .word_idx_o(widx),
    .word_vld_o(vld), .done_o(done), .frame_err_o(ferr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // chain model: next bit presented on each rising data clock edge
  always @(posedge sclk) begin
    pulse_cnt++;
    sdata = (sb_ptr < sb_len) ? sb[sb_ptr] : 1'b0;
    sb_ptr++;
  end

  always @(negedge clk) begin
    if (sclk) hi_cnt++;
    if (rd) rd_cnt++;
    if (done) begin
      done_cnt++;
      chk(vld_last_d, "R8", "done right after last word", 0, 1);
    end
    vld_last_d = 1'b0;
    if (vld) begin
      got_words++;
      chk(int'(widx) == next_idx, "R5", "word index", widx, next_idx);
      chk(word == exp_word[widx], "R5", "word value", word, exp_word[widx]);
      vld_last_d = (int'(widx) == exp_n - 1);
      next_idx++;
    end
  end

  task automatic run_burst(input int n, input bit s, input int h,
                           input bit bad_sep, input bit poke);
    int idx = 0;
    int t = 0;
    int ph = (h == 0) ? 1 : h;
    int exp_p = 17 * n - 1 + int'(s);
    for (int d = 0; d < n; d++)
      exp_word[d] = 16'((32'hB3D1 * (d + 1)) + n * 97 + h * 13 + int'(s));
    if (s) begin sb[idx] = 1'b1; idx++; end
    for (int d = 0; d < n; d++) begin
      for (int b = 15; b >= 0; b--) begin sb[idx] = exp_word[d][b]; idx++; end
      if (d < n - 1) begin sb[idx] = bad_sep; idx++; end
    end
    sb_len = idx; sb_ptr = 0; pulse_cnt = 0; hi_cnt = 0;
    got_words = 0; next_idx = 0; done_cnt = 0; rd_cnt = 0; exp_n = n;
    @(negedge clk);
    start = 1'b1; len = LEN_W'(n); sync_en = s; half = DIV_W'(h);
    @(negedge clk);
    start = 1'b0;
    chk(rd == 1'b1, "R2", "read strobe after start", rd, 1);
    // R9: scramble configuration during the burst
    len = '0; half = DIV_W'(7); sync_en = ~s;
    @(negedge clk);
    chk(rd == 1'b0, "R2", "read strobe width", rd, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; len = LEN_W'(1);
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R8", "burst completes", t, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", done, 0);
    chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    chk(sclk == 1'b0, "R8", "clock low after burst", sclk, 0);
    chk(got_words == n, "R5", "words delivered", got_words, n);
    chk(pulse_cnt == exp_p, s ? "R6" : "R3", "clock pulses", pulse_cnt, exp_p);
    chk(hi_cnt == exp_p * ph, "R4", "clock high cycles", hi_cnt, exp_p * ph);
    chk(rd_cnt == 1, poke ? "R9" : "R2", "strobes per burst", rd_cnt, 1);
    chk(ferr == (bad_sep && n > 1), "R7", "frame error", ferr, bad_sep && n > 1);
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0 && pulse_cnt == exp_p, "R3", "clock idle after burst",
        pulse_cnt, exp_p);
  endtask

  task automatic bad_start(input int l);
    rd_cnt = 0; pulse_cnt = 0;
    @(negedge clk);
    start = 1'b1; len = LEN_W'(l); half = DIV_W'(1);
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0 && pulse_cnt == 0, "R2", "illegal length ignored",
        rd_cnt + pulse_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({sclk, rd, vld, done, ferr} == 5'b0, "R1", "outputs in reset",
        {sclk, rd, vld, done, ferr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({sclk, rd, vld, done, ferr} == 5'b0, "R1", "outputs after reset",
        {sclk, rd, vld, done, ferr}, 0);
    bad_start(0);
    bad_start(5);
    bad_start(7);
    for (int n = 1; n <= MAX_DEV; n++)
      for (int s = 0; s < 2; s++)
        for (int h = 0; h < 4; h++)
          run_burst(n, s[0], h, 1'b0, 1'b0);
    run_burst(3, 1'b0, 2, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    chk(ferr == 1'b1, "R7", "frame error held while idle", ferr, 1);
    run_burst(4, 1'b1, 1, 1'b1, 1'b1);
    run_burst(2, 1'b0, 1, 1'b0, 1'b1);
    run_burst(1, 1'b1, 3, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "R8", "watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule